// File: doc/BRIEF.md
# Serial Flash Geometry Probe

This block finds out which serial page-organised flash is attached to a byte-transfer engine, and what shape its memory has. On a probe request it first asks the device for its three-byte JEDEC identity. When the manufacturer byte is the expected one, the device code is looked up in a built-in table. For parts that can run with either page size, one more status read settles whether the part is in binary-page mode (status bit 0 set) or extended-page mode. When the manufacturer byte is anything else, the block falls back to one status read and takes the density from status bits [5:2].

The result is a page count, a page size in bytes and the shift that places the page number inside a flash byte address. It is flagged by `geo_valid`, or an error is flagged by `err_valid` together with a code. The result stays in place until the next probe request. The block does not drive the serial lines. It asks an external byte engine for a transfer (opcode plus reply length) and takes the reply bytes one per `rx_valid` pulse.

The state machine has eleven states:

| State | Action and transitions |
|---|---|
| IDLE | Out of reset. `start` moves to ID_CMD. |
| ID_CMD | Issues the identity request, then moves to ID_RX. |
| ID_RX | Takes three bytes, then moves to ID_EVAL. |
| ID_EVAL | Moves to LEG_CMD on a foreign manufacturer, to ST_CMD on a dual-mode part, and to DONE otherwise. |
| ST_CMD | Issues the status request, then moves to ST_RX. |
| ST_RX | Takes one byte, then moves to ST_EVAL. |
| ST_EVAL | Moves to DONE. |
| LEG_CMD | Issues the status request, then moves to LEG_RX. |
| LEG_RX | Takes one byte, then moves to LEG_EVAL. |
| LEG_EVAL | Moves to DONE. |
| DONE | `start` moves back to ID_CMD. |

Top module: `dfp_probe`

## Requirements
- R1: A `start` pulse while not busy raises `busy` on the next cycle. In that same cycle it issues a one-cycle `xfer_req` with `xfer_op` = 0x9F and `xfer_nbytes` = 3.
- R2: When the first identity byte is not 0x1F, exactly one status request follows (`xfer_op` = 0xD7, `xfer_nbytes` = 1), and the result comes from the legacy decode.
- R3: With manufacturer 0x1F, the device bytes give these page counts:

  | Device bytes | Page count |
  |---|---|
  | 22 00 | 512 |
  | 23 00 | 1024 |
  | 24 00 | 2048 |
  | 25 00 | 4096 |
  | 26 00 | 4096 |
  | 27 00 | 8192 |
  | 27 01 | 8192 |
  | 28 00 | 8192 |

- R4: Every entry except 27 00 is dual-mode and triggers one status read. Status bit 0 = 1 selects the binary page sizes, and bit 0 = 0 selects the extended sizes:

  | Device bytes | Binary size / shift | Extended size / shift |
  |---|---|---|
  | 22 to 25 | 256 / 8 | 264 / 9 |
  | 26 and 27 01 | 512 / 9 | 528 / 10 |
  | 28 | 1024 / 10 | 1056 / 11 |

- R5: Identity 1F 27 00 gives 8192 pages of 528 bytes with shift 10, and no status read is issued.
- R6: A 0x1F identity not in the table ends with `err_valid` and `err_code` = 1 (unknown identity), with no status read.
- R7: On the legacy path, a status byte of 0x00 or 0xFF ends with `err_code` = 2 (no device).
- R8: On the legacy path, status & 0x3C decodes as follows (pages / size / shift):

  | status & 0x3C | Pages / size / shift |
  |---|---|
  | 0x0C | 512 / 264 / 9 |
  | 0x14 | 1024 / 264 / 9 |
  | 0x1C | 2048 / 264 / 9 |
  | 0x24 | 4096 / 264 / 9 |
  | 0x2C | 4096 / 528 / 10 |
  | 0x34 | 8192 / 528 / 10 |
  | 0x38 or 0x3C | 8192 / 1056 / 11 |

- R9: Any other legacy density ends with `err_code` = 3 (unsupported density).
- R10: When `busy` falls, exactly one of `geo_valid` and `err_valid` is set, and `err_code` is 0 exactly when `geo_valid` is set. Both flags, the code and the geometry hold until the next accepted `start`, which clears both flags on the following cycle.
- R11: A `start` while `busy` is ignored. The probe under way issues no extra identity request and finishes with its own result.
- R12: After reset, `busy`, `geo_valid`, `err_valid` and `xfer_req` are low until a `start` is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Probe request pulse |
| busy | output | 1 | Probe in progress |
| xfer_req | output | 1 | One-cycle transfer request to the byte engine |
| xfer_op | output | 8 | Opcode of the requested transfer |
| xfer_nbytes | output | 2 | Number of reply bytes expected |
| rx_valid | input | 1 | Reply byte strobe |
| rx_byte | input | 8 | Reply byte |
| geo_valid | output | 1 | Geometry outputs are valid |
| err_valid | output | 1 | Probe ended in error |
| err_code | output | 2 | 0 none, 1 unknown identity, 2 no device, 3 unsupported density |
| page_count | output | 14 | Number of pages |
| page_bytes | output | 11 | Page size in bytes |
| page_shift | output | 4 | Bit position of the page number in a byte address |

## Verification
The bench builds the block with its default widths: 14 bits of page count, 11 bits of page size and 4 bits of shift. These are just wide enough for the largest results, 8192 pages and 1056-byte pages with shift 11, so every table entry and every legacy density code can be observed without truncation. The identity reply length of three lets the bench's device model answer both request kinds. Its request counters show which path a probe took.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ID_CMD,
        S_ID_RX,
        S_ID_EVAL,
        S_ST_CMD,
        S_ST_RX,
        S_ST_EVAL,
        S_LEG_CMD,
        S_LEG_RX,
        S_LEG_EVAL,
        S_DONE
    } dfp_state_t;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_UNKNOWN_ID = 2'd1,
        ERR_NO_DEVICE  = 2'd2,
        ERR_BAD_DENS   = 2'd3
    } dfp_err_t;

    // size class: 0 = 256/264-byte pages, 1 = 512/528, 2 = 1024/1056
    typedef logic [1:0] dfp_cls_t;

endpackage

// File: rtl/dfp_jedec_map.sv
module dfp_jedec_map
    import dfp_pkg::*;
#(
    parameter int PAGES_W = 14
) (
    input  logic [7:0]         dev_hi,
    input  logic [7:0]         dev_lo,
    output logic               hit,
    output logic               dual,
    output dfp_cls_t           cls,
    output logic [PAGES_W-1:0] pages
);
    logic [7:0] rel;
    assign rel = dev_hi - 8'h22;

    always_comb begin
        hit   = 1'b0;
        dual  = 1'b1;
        cls   = 2'd0;
        pages = '0;
        unique case (dev_hi)
            8'h22, 8'h23, 8'h24, 8'h25: begin
                hit   = (dev_lo == 8'h00);
                pages = PAGES_W'(512) << rel[1:0];
            end
            8'h26: begin
                hit   = (dev_lo == 8'h00);
                cls   = 2'd1;
                pages = PAGES_W'(4096);
            end
            8'h27: begin
                hit   = (dev_lo == 8'h00) || (dev_lo == 8'h01);
                dual  = (dev_lo == 8'h01);
                cls   = 2'd1;
                pages = PAGES_W'(8192);
            end
            8'h28: begin
                hit   = (dev_lo == 8'h00);
                cls   = 2'd2;
                pages = PAGES_W'(8192);
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dfp_legacy_map.sv
module dfp_legacy_map
    import dfp_pkg::*;
#(
    parameter int PAGES_W = 14
) (
    input  logic [3:0]         dens,
    output logic               supported,
    output dfp_cls_t           cls,
    output logic [PAGES_W-1:0] pages
);
    always_comb begin
        supported = 1'b1;
        cls       = 2'd0;
        pages     = '0;
        unique case (dens)
            4'h3: pages = PAGES_W'(512);
            4'h5: pages = PAGES_W'(1024);
            4'h7: pages = PAGES_W'(2048);
            4'h9: pages = PAGES_W'(4096);
            4'hB: begin cls = 2'd1; pages = PAGES_W'(4096); end
            4'hD: begin cls = 2'd1; pages = PAGES_W'(8192); end
            4'hE, 4'hF: begin cls = 2'd2; pages = PAGES_W'(8192); end
            default: supported = 1'b0;
        endcase
    end
endmodule

// File: rtl/dfp_geom.sv
module dfp_geom
    import dfp_pkg::*;
#(
    parameter int SIZE_W   = 11,
    parameter int SHIFT_W  = 4,
    parameter int BIN_BASE = 256,
    parameter int EXT_BASE = 264,
    parameter int BIN_SHFT = 8
) (
    input  dfp_cls_t           cls,
    input  logic               binary,
    output logic [SIZE_W-1:0]  bytes_out,
    output logic [SHIFT_W-1:0] shift_out
);
    localparam logic [SIZE_W-1:0]  BIN_B = SIZE_W'(BIN_BASE);
    localparam logic [SIZE_W-1:0]  EXT_B = SIZE_W'(EXT_BASE);
    localparam logic [SHIFT_W-1:0] BIN_S = SHIFT_W'(BIN_SHFT);

    always_comb begin
        bytes_out = (binary ? BIN_B : EXT_B) << cls;
        shift_out = BIN_S + SHIFT_W'(cls) + SHIFT_W'(!binary);
    end
endmodule

// File: rtl/dfp_probe.sv
module dfp_probe
    import dfp_pkg::*;
#(
    parameter int         PAGES_W = 14,
    parameter int         SIZE_W  = 11,
    parameter int         SHIFT_W = 4,
    parameter int         ID_LEN  = 3,
    parameter logic [7:0] OP_ID   = 8'h9F,
    parameter logic [7:0] OP_STAT = 8'hD7,
    parameter logic [7:0] MFR     = 8'h1F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               xfer_req,
    output logic [7:0]         xfer_op,
    output logic [1:0]         xfer_nbytes,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    output logic               geo_valid,
    output logic               err_valid,
    output logic [1:0]         err_code,
    output logic [PAGES_W-1:0] page_count,
    output logic [SIZE_W-1:0]  page_bytes,
    output logic [SHIFT_W-1:0] page_shift
);
    localparam int CNT_W = $clog2(ID_LEN);

    dfp_state_t          state, nxt;
    logic [CNT_W-1:0]    cnt;
    logic [7:0]          id_q [ID_LEN];
    logic [7:0]          stat_q;

    logic                j_hit, j_dual, l_ok, l_present, g_bin;
    dfp_cls_t            j_cls, l_cls, g_cls;
    logic [PAGES_W-1:0]  j_pages, l_pages, g_pages;
    logic [SIZE_W-1:0]   g_bytes;
    logic [SHIFT_W-1:0]  g_shift;
    logic                accept;

    assign accept = start && (state == S_IDLE || state == S_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_ID_CMD;
            S_ID_CMD:   nxt = S_ID_RX;
            S_ID_RX:    if (rx_valid && cnt == CNT_W'(ID_LEN-1)) nxt = S_ID_EVAL;
            S_ID_EVAL: begin
                if (id_q[0] != MFR)  nxt = S_LEG_CMD;
                else if (!j_hit)     nxt = S_DONE;
                else if (j_dual)     nxt = S_ST_CMD;
                else                 nxt = S_DONE;
            end
            S_ST_CMD:   nxt = S_ST_RX;
            S_ST_RX:    if (rx_valid) nxt = S_ST_EVAL;
            S_ST_EVAL:  nxt = S_DONE;
            S_LEG_CMD:  nxt = S_LEG_RX;
            S_LEG_RX:   if (rx_valid) nxt = S_LEG_EVAL;
            S_LEG_EVAL: nxt = S_DONE;
            S_DONE:     if (start) nxt = S_ID_CMD;
            default:    nxt = S_IDLE;
        endcase
    end

    // Moore outputs towards the byte engine
    always_comb begin
        busy        = !(state == S_IDLE || state == S_DONE);
        xfer_req    = 1'b0;
        xfer_op     = OP_STAT;
        xfer_nbytes = 2'd1;
        unique case (state)
            S_ID_CMD: begin
                xfer_req    = 1'b1;
                xfer_op     = OP_ID;
                xfer_nbytes = 2'(ID_LEN);
            end
            S_ST_CMD, S_LEG_CMD: xfer_req = 1'b1;
            default: ;
        endcase
    end

    // reply capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            stat_q <= '0;
        end else begin
            if (state == S_ID_CMD)
                cnt <= '0;
            else if (state == S_ID_RX && rx_valid)
                cnt <= cnt + 1'b1;
            if ((state == S_ST_RX || state == S_LEG_RX) && rx_valid)
                stat_q <= rx_byte;
        end
    end

    for (genvar gi = 0; gi < ID_LEN; gi++) begin : g_id
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                id_q[gi] <= '0;
            else if (state == S_ID_RX && rx_valid && cnt == CNT_W'(gi))
                id_q[gi] <= rx_byte;
        end
    end

    dfp_jedec_map #(.PAGES_W(PAGES_W)) i_jmap (
        .dev_hi (id_q[1]),
        .dev_lo (id_q[2]),
        .hit    (j_hit),
        .dual   (j_dual),
        .cls    (j_cls),
        .pages  (j_pages)
    );

    dfp_legacy_map #(.PAGES_W(PAGES_W)) i_lmap (
        .dens      (stat_q[5:2]),
        .supported (l_ok),
        .cls       (l_cls),
        .pages     (l_pages)
    );

    assign l_present = !(stat_q == 8'h00 || stat_q == 8'hFF);
    assign g_bin     = (state == S_ST_EVAL) && stat_q[0];
    assign g_cls     = (state == S_LEG_EVAL) ? l_cls : j_cls;
    assign g_pages   = (state == S_LEG_EVAL) ? l_pages : j_pages;

    dfp_geom #(.SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W)) i_geom (
        .cls       (g_cls),
        .binary    (g_bin),
        .bytes_out (g_bytes),
        .shift_out (g_shift)
    );

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            geo_valid  <= 1'b0;
            err_valid  <= 1'b0;
            err_code   <= ERR_NONE;
            page_count <= '0;
            page_bytes <= '0;
            page_shift <= '0;
        end else if (accept) begin
            geo_valid <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            unique case (state)
                S_ID_EVAL: begin
                    if (id_q[0] == MFR && !j_hit) begin
                        err_valid <= 1'b1;
                        err_code  <= ERR_UNKNOWN_ID;
                    end else if (id_q[0] == MFR && !j_dual) begin
                        geo_valid  <= 1'b1;
                        page_count <= g_pages;
                        page_bytes <= g_bytes;
                        page_shift <= g_shift;
                    end
                end
                S_ST_EVAL: begin
                    geo_valid  <= 1'b1;
                    page_count <= g_pages;
                    page_bytes <= g_bytes;
                    page_shift <= g_shift;
                end
                S_LEG_EVAL: begin
                    if (!l_present) begin
                        err_valid <= 1'b1;
                        err_code  <= ERR_NO_DEVICE;
                    end else if (!l_ok) begin
                        err_valid <= 1'b1;
                        err_code  <= ERR_BAD_DENS;
                    end else begin
                        geo_valid  <= 1'b1;
                        page_count <= g_pages;
                        page_bytes <= g_bytes;
                        page_shift <= g_shift;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dfp_probe_chk.sv
module dfp_probe_chk #(
    parameter int         PAGES_W = 14,
    parameter int         SIZE_W  = 11,
    parameter int         SHIFT_W = 4,
    parameter int         ID_LEN  = 3,
    parameter logic [7:0] OP_ID   = 8'h9F
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               xfer_req,
    input logic [7:0]         xfer_op,
    input logic [1:0]         xfer_nbytes,
    input logic               geo_valid,
    input logic               err_valid,
    input logic [1:0]         err_code,
    input logic [PAGES_W-1:0] page_count,
    input logic [SIZE_W-1:0]  page_bytes,
    input logic [SHIFT_W-1:0] page_shift
);
    p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (xfer_req && xfer_op == OP_ID && xfer_nbytes == 2'(ID_LEN)));

    p_errcode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != 2'd0));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(geo_valid && err_valid));

    p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (geo_valid || err_valid));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid && !start) |=> (geo_valid && $stable(page_count)
                                   && $stable(page_bytes) && $stable(page_shift)));

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_req);
endmodule

bind dfp_probe dfp_probe_chk #(
    .PAGES_W (PAGES_W),
    .SIZE_W  (SIZE_W),
    .SHIFT_W (SHIFT_W),
    .ID_LEN  (ID_LEN),
    .OP_ID   (OP_ID)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .xfer_req    (xfer_req),
    .xfer_op     (xfer_op),
    .xfer_nbytes (xfer_nbytes),
    .geo_valid   (geo_valid),
    .err_valid   (err_valid),
    .err_code    (err_code),
    .page_count  (page_count),
    .page_bytes  (page_bytes),
    .page_shift  (page_shift)
);

// File: tb/test_dfp_probe.sv
module test_dfp_probe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, xfer_req, rx_valid = 1'b0;
    logic [7:0]  xfer_op, rx_byte = 8'h00;
    logic [1:0]  xfer_nbytes, err_code;
    logic        geo_valid, err_valid;
    logic [13:0] page_count;
    logic [10:0] page_bytes;
    logic [3:0]  page_shift;

    always #10 clk = ~clk;

    dfp_probe i_dfp_probe (
        .clk, .rst_n, .start, .busy, .xfer_req, .xfer_op, .xfer_nbytes,
        .rx_valid, .rx_byte, .geo_valid, .err_valid, .err_code,
        .page_count, .page_bytes, .page_shift
    );

    // {id0,id1,id2,status, ok, err, pages, size, shift, status_reads}
    localparam int NV = 24;
    localparam logic [65:0] VEC [NV] = '{
        {8'h1F,8'h22,8'h00,8'h01,1'b1,2'd0,14'd512, 11'd256, 4'd8, 2'd1}, // R3 R4
        {8'h1F,8'h22,8'h00,8'h00,1'b1,2'd0,14'd512, 11'd264, 4'd9, 2'd1}, // R4
        {8'h1F,8'h23,8'h00,8'h01,1'b1,2'd0,14'd1024,11'd256, 4'd8, 2'd1}, // R3
        {8'h1F,8'h24,8'h00,8'h00,1'b1,2'd0,14'd2048,11'd264, 4'd9, 2'd1}, // R3
        {8'h1F,8'h25,8'h00,8'h81,1'b1,2'd0,14'd4096,11'd256, 4'd8, 2'd1}, // R3
        {8'h1F,8'h26,8'h00,8'h81,1'b1,2'd0,14'd4096,11'd512, 4'd9, 2'd1}, // R4
        {8'h1F,8'h26,8'h00,8'hFE,1'b1,2'd0,14'd4096,11'd528, 4'd10,2'd1}, // R4
        {8'h1F,8'h28,8'h00,8'h80,1'b1,2'd0,14'd8192,11'd1056,4'd11,2'd1}, // R4
        {8'h1F,8'h28,8'h00,8'h01,1'b1,2'd0,14'd8192,11'd1024,4'd10,2'd1}, // R4
        {8'h1F,8'h27,8'h00,8'h01,1'b1,2'd0,14'd8192,11'd528, 4'd10,2'd0}, // R5
        {8'h1F,8'h27,8'h01,8'h01,1'b1,2'd0,14'd8192,11'd512, 4'd9, 2'd1}, // R4
        {8'h1F,8'h29,8'h00,8'h01,1'b0,2'd1,14'd0,   11'd0,   4'd0, 2'd0}, // R6
        {8'h1F,8'h22,8'h05,8'h01,1'b0,2'd1,14'd0,   11'd0,   4'd0, 2'd0}, // R6
        {8'hC2,8'h22,8'h00,8'h00,1'b0,2'd2,14'd0,   11'd0,   4'd0, 2'd1}, // R2 R7
        {8'hFF,8'hFF,8'hFF,8'hFF,1'b0,2'd2,14'd0,   11'd0,   4'd0, 2'd1}, // R7
        {8'h00,8'h00,8'h00,8'h8C,1'b1,2'd0,14'd512, 11'd264, 4'd9, 2'd1}, // R8
        {8'h00,8'h00,8'h00,8'h14,1'b1,2'd0,14'd1024,11'd264, 4'd9, 2'd1}, // R8
        {8'h00,8'h00,8'h00,8'h9C,1'b1,2'd0,14'd2048,11'd264, 4'd9, 2'd1}, // R8
        {8'h00,8'h00,8'h00,8'hA4,1'b1,2'd0,14'd4096,11'd264, 4'd9, 2'd1}, // R8
        {8'h00,8'h00,8'h00,8'h2D,1'b1,2'd0,14'd4096,11'd528, 4'd10,2'd1}, // R8
        {8'h00,8'h00,8'h00,8'hB4,1'b1,2'd0,14'd8192,11'd528, 4'd10,2'd1}, // R8
        {8'h00,8'h00,8'h00,8'h38,1'b1,2'd0,14'd8192,11'd1056,4'd11,2'd1}, // R8
        {8'h00,8'h00,8'h00,8'h3F,1'b1,2'd0,14'd8192,11'd1056,4'd11,2'd1}, // R8
        {8'h00,8'h00,8'h00,8'h90,1'b0,2'd3,14'd0,   11'd0,   4'd0, 2'd1}  // R9
    };

    int n_chk = 0, n_bad = 0, cyc = 0;
    int id_reads = 0, st_reads = 0, bad_reqs = 0;
    logic [7:0] cur_id [3];
    logic [7:0] cur_st;
    logic [7:0] r_op;
    int         r_n;
    bit         ended = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // device model behind the byte engine
    always begin
        @(negedge clk);
        if (xfer_req) begin
            r_op = xfer_op;
            r_n  = int'(xfer_nbytes);
            if (r_op == 8'h9F && r_n == 3)      id_reads++;
            else if (r_op == 8'hD7 && r_n == 1) st_reads++;
            else                                bad_reqs++;
            repeat (2) @(negedge clk);
            for (int k = 0; k < r_n; k++) begin
                rx_valid = 1'b1;
                rx_byte  = (r_op == 8'h9F) ? cur_id[k] : cur_st;
                @(negedge clk);
                rx_valid = 1'b0;
                if (k < r_n - 1) @(negedge clk);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            if (!busy && (geo_valid || err_valid)) break;
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [65:0] v);
        cur_id[0] = v[65:58];
        cur_id[1] = v[57:50];
        cur_id[2] = v[49:42];
        cur_st    = v[41:34];
    endtask

    initial begin
        int s0, i0, b0;
        logic [13:0] hold_p;
        repeat (5) @(negedge clk);
        // R12: reset state
        chk(busy == 0 && geo_valid == 0 && err_valid == 0, "R12 flags after reset",
            {busy, geo_valid, err_valid}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 0 && geo_valid == 0 && err_valid == 0 && id_reads == 0,
            "R12 idle without start", {busy, geo_valid, err_valid} + id_reads, 0);

        for (int v = 0; v < NV; v++) begin
            load(VEC[v]);
            s0 = st_reads; i0 = id_reads; b0 = bad_reqs;
            pulse_start();
            wait_done();
            chk(id_reads - i0 == 1 && bad_reqs == b0, "R1 identity request",
                id_reads - i0, 1);
            chk(st_reads - s0 == int'(VEC[v][1:0]), "R2 R4 R5 R6 status reads",
                st_reads - s0, int'(VEC[v][1:0]));
            chk(geo_valid == VEC[v][33] && err_valid == !VEC[v][33], "R10 result flag",
                geo_valid, VEC[v][33]);
            chk(err_code == VEC[v][32:31], "R6 R7 R9 error code",
                err_code, VEC[v][32:31]);
            if (VEC[v][33]) begin
                chk(page_count == VEC[v][30:17], "R3 R8 page count",
                    page_count, VEC[v][30:17]);
                chk(page_bytes == VEC[v][16:6], "R4 R5 R8 page size",
                    page_bytes, VEC[v][16:6]);
                chk(page_shift == VEC[v][5:2], "R4 R5 R8 page shift",
                    page_shift, VEC[v][5:2]);
            end
        end

        // R10: hold across idle cycles, then restart clears the flags
        load(VEC[7]);
        pulse_start();
        wait_done();
        hold_p = page_count;
        repeat (30) @(negedge clk);
        chk(geo_valid && page_count == hold_p && page_bytes == 11'd1056,
            "R10 result held", page_count, hold_p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!geo_valid && !err_valid, "R10 restart clears flags", geo_valid, 0);
        wait_done();
        chk(geo_valid && page_count == 14'd8192, "R10 restart result", page_count, 8192);

        // R11: start during a busy probe is ignored
        load(VEC[0]);
        i0 = id_reads;
        pulse_start();
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk(id_reads - i0 == 1, "R11 no extra identity request", id_reads - i0, 1);
        chk(geo_valid && page_bytes == 11'd256, "R11 own result kept", page_bytes, 256);

        // R12: reset mid-probe returns to idle
        pulse_start();
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !geo_valid && !err_valid, "R12 reset during probe",
            {busy, geo_valid, err_valid}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule